// File: doc/BRIEF.md
# BCD Calendar Clock with Exact-Match Alarm

This block is a real-time clock core advanced by a slow tick enable (nominally 32.768 kHz) that arrives on the fast system clock. A prescaler divides the tick into one update per second. Each update advances a packed-BCD calendar of seconds, minutes, hours (24-hour), day, month and two-digit year (00..99 meaning 2000..2099). Carries ripple through the fields, and the month length includes February 29 in leap years. A bank of six alarm fields is compared against the calendar after every update. The alarm fires only when all six fields are equal.

Software reaches the block through a byte-wide register port with a combinational read. A status bit marks the last tick period before each update. Software waits for that bit to fall and then uses the quiet window that follows. While the clock runs, a time write is staged and applied at the next tick, so a written value is never lost. While the clock is stopped, a time write loads directly. Event flags and the alarm flag are write-one-to-clear. Two interrupt lines are provided: a one-cycle timer pulse on every update, and an alarm level.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the calendar reads 00:00:00 on day 01, month 01, year 00. Control, status, interrupt-enable and all alarm fields read 0x00.
- R2: Register map (byte values, address bits 1:0 zero):
  - Time fields at 0x00 sec, 0x04 min, 0x08 hour, 0x0C day, 0x10 month, 0x14 year.
  - Alarm fields at 0x20..0x34 in the same field order.
  - Control at 0x40, where bit 0 = run.
  - Status at 0x44, where bit 1 mirrors run.
  - Interrupt enable at 0x48, where bit 2 = timer and bit 3 = alarm.
- R3: With run = 0, a time write loads immediately and the calendar holds its value.
- R4: With run = 1, seconds advance by one in packed BCD once every TICKS_PER_SEC tick enables, including the carry from digit 9 to the tens digit.
- R5: Status bit 0 (busy) is high during the last tick period before each update and low after the update. Busy stays low while the clock is stopped.
- R6: Carries: seconds and minutes wrap 59→00, hours wrap 23→00, day wraps to 01 after the month's last day, month wraps 12→01, and year wraps 99→00.
- R7: February has 29 days when the year is divisible by 4 and 28 days otherwise.
- R8: Status event bits are set on updates:
  - bit 2 on every update;
  - bit 3 when minutes change;
  - bit 4 when hours change;
  - bit 5 when the day changes.
  Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: One cycle after an update that makes all six alarm fields equal to the calendar, status bit 6 is set. irq_alarm_o equals status bit 6 AND enable bit 3. Writing 1 to status bit 6 clears it.
- R10: If any one alarm field differs from the calendar, no alarm flag is set.
- R11: With enable bit 2 set, irq_timer_o is a one-cycle pulse once per update. With the bit clear, irq_timer_o stays low.
- R12: With run = 1, a time write takes effect at the next tick enable and is not overwritten by the update, even when it is issued while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable per slow oscillator period |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational from addr_i) |
| irq_timer_o | output | 1 | One-cycle pulse per second update when enabled |
| irq_alarm_o | output | 1 | Alarm interrupt level |

## Verification
The bench builds the core with TICKS_PER_SEC = 8 and pulses tick_i every second cycle, so one calendar second lasts 16 clock cycles. This makes month, year and century rollovers and leap-day cases reachable in a handful of updates after a stopped-clock preload. It also gives busy a two-cycle window, which is wide enough for the bench to land a write inside it and confirm that the staged value survives the update.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NF = 6;
  localparam int F_SEC = 0;
  localparam int F_MIN = 1;
  localparam int F_HR  = 2;
  localparam int F_DAY = 3;
  localparam int F_MON = 4;
  localparam int F_YR  = 5;

  typedef logic [NF-1:0][7:0] cal_t;

  localparam cal_t CAL_RST = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v,
                                         input logic [7:0] last,
                                         input logic [7:0] first);
    if (v == last) return first;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon,
                                            input logic [7:0] yr);
    case (mon)
      8'h02: return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic busy_o,
  output logic upd_o
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q == LAST);
  assign upd_o  = run_i && tick_i && busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (tick_i)    cnt_q <= busy_o ? '0 : cnt_q + 1'b1;
  end

  AST_BUSY_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && $past(!run_i)) |-> !busy_o); // R5
  AST_BUSY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !busy_o); // R5
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic       upd_i,
  input  logic       wr_i,
  input  logic [2:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  output cal_t       cal_o,
  output logic       min_evt_o,
  output logic       hr_evt_o,
  output logic       day_evt_o
);
  logic [7:0] cur_q [NF];
  logic [7:0] pd_q  [NF];
  logic       pv_q  [NF];
  logic [7:0] nxt   [NF];
  logic       sec_w, min_w, hr_w, day_w, mon_w, pend_any;
  logic       apply;

  assign apply = tick_i || !run_i;

  always_comb begin
    sec_w = (cur_q[F_SEC] == 8'h59);
    min_w = sec_w && (cur_q[F_MIN] == 8'h59);
    hr_w  = min_w && (cur_q[F_HR] == 8'h23);
    day_w = hr_w && (cur_q[F_DAY] == month_last(cur_q[F_MON], cur_q[F_YR]));
    mon_w = day_w && (cur_q[F_MON] == 8'h12);
    nxt[F_SEC] = bcd_inc(cur_q[F_SEC], 8'h59, 8'h00);
    nxt[F_MIN] = sec_w ? bcd_inc(cur_q[F_MIN], 8'h59, 8'h00) : cur_q[F_MIN];
    nxt[F_HR]  = min_w ? bcd_inc(cur_q[F_HR], 8'h23, 8'h00) : cur_q[F_HR];
    nxt[F_DAY] = hr_w ? bcd_inc(cur_q[F_DAY],
                                month_last(cur_q[F_MON], cur_q[F_YR]), 8'h01)
                      : cur_q[F_DAY];
    nxt[F_MON] = day_w ? bcd_inc(cur_q[F_MON], 8'h12, 8'h01) : cur_q[F_MON];
    nxt[F_YR]  = mon_w ? bcd_inc(cur_q[F_YR], 8'h99, 8'h00) : cur_q[F_YR];
    pend_any = 1'b0;
    for (int i = 0; i < NF; i++) pend_any = pend_any | pv_q[i];
  end

  assign min_evt_o = upd_i && sec_w;
  assign hr_evt_o  = upd_i && min_w;
  assign day_evt_o = upd_i && hr_w;

  for (genvar f = 0; f < NF; f++) begin : g_fld
    logic sel;
    assign sel = wr_i && (wr_idx_i == 3'(f));
    assign cal_o[f] = cur_q[f];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q[f] <= CAL_RST[f];
        pd_q[f]  <= 8'h00;
        pv_q[f]  <= 1'b0;
      end else begin
        if (apply) begin
          if (pv_q[f])    cur_q[f] <= pd_q[f];
          else if (upd_i) cur_q[f] <= nxt[f];
          pv_q[f] <= 1'b0;
        end
        if (sel) begin
          if (run_i) begin
            pd_q[f] <= wr_data_i;
            pv_q[f] <= 1'b1;
          end else begin
            cur_q[f] <= wr_data_i;
            pv_q[f]  <= 1'b0;
          end
        end
      end
    end
  end

  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_i && !upd_i && !pend_any) |=> $stable(cal_o)); // R3
  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !pv_q[F_SEC] && !(wr_i && wr_idx_i == 3'd0) && cal_o[F_SEC] == 8'h59)
    |=> cal_o[F_SEC] == 8'h00); // R6
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  cal_t       cal_i,
  output cal_t       alm_o,
  output logic       match_o
);
  logic [NF-1:0] eq;

  for (genvar f = 0; f < NF; f++) begin : g_alm
    logic [7:0] a_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              a_q <= 8'h00;
      else if (wr_i && (wr_idx_i == 3'(f)))     a_q <= wr_data_i;
    end
    assign alm_o[f] = a_q;
    assign eq[f]    = (a_q == cal_i[f]);
  end

  assign match_o = &eq;
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_timer_o,
  output logic       irq_alarm_o
);
  localparam logic [7:0] A_CTRL = 8'h40;
  localparam logic [7:0] A_STAT = 8'h44;
  localparam logic [7:0] A_IEN  = 8'h48;

  logic [2:0] fld;
  logic       aligned, fld_ok, wr_time, wr_alm, wr_ctrl, wr_stat, wr_ien;
  logic       run_q, upd_q, alm_flag_q, irq_timer_q;
  logic [1:0] ien_q;
  logic [3:0] evt_q, evt_set;
  logic       busy, upd, match, min_evt, hr_evt, day_evt, alarm_hit;
  cal_t       cal, alm;

  assign fld     = addr_i[4:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign fld_ok  = (fld <= 3'd5);
  assign wr_time = we_i && aligned && fld_ok && (addr_i[7:5] == 3'b000);
  assign wr_alm  = we_i && aligned && fld_ok && (addr_i[7:5] == 3'b001);
  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_stat = we_i && (addr_i == A_STAT);
  assign wr_ien  = we_i && (addr_i == A_IEN);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .tick_i (tick_i),
    .busy_o (busy),
    .upd_o  (upd)
  );

  rtc_calendar u_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .tick_i    (tick_i),
    .upd_i     (upd),
    .wr_i      (wr_time),
    .wr_idx_i  (fld),
    .wr_data_i (wdata_i),
    .cal_o     (cal),
    .min_evt_o (min_evt),
    .hr_evt_o  (hr_evt),
    .day_evt_o (day_evt)
  );

  rtc_alarm u_alm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_alm),
    .wr_idx_i  (fld),
    .wr_data_i (wdata_i),
    .cal_i     (cal),
    .alm_o     (alm),
    .match_o   (match)
  );

  assign evt_set   = {day_evt, hr_evt, min_evt, upd};
  assign alarm_hit = upd_q && match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      ien_q       <= 2'b00;
      upd_q       <= 1'b0;
      alm_flag_q  <= 1'b0;
      irq_timer_q <= 1'b0;
    end else begin
      if (wr_ctrl) run_q <= wdata_i[0];
      if (wr_ien)  ien_q <= wdata_i[3:2];
      upd_q       <= upd;
      irq_timer_q <= upd && ien_q[0];
      if (alarm_hit)                  alm_flag_q <= 1'b1;
      else if (wr_stat && wdata_i[6]) alm_flag_q <= 1'b0;
    end
  end

  for (genvar e = 0; e < 4; e++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        evt_q[e] <= 1'b0;
      else if (evt_set[e])                evt_q[e] <= 1'b1;
      else if (wr_stat && wdata_i[e+2])   evt_q[e] <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i[7:5])
      3'b000: if (aligned && fld_ok) rdata_o = cal[fld];
      3'b001: if (aligned && fld_ok) rdata_o = alm[fld];
      default: begin
        if (addr_i == A_CTRL) rdata_o = {7'b0, run_q};
        if (addr_i == A_STAT) rdata_o = {1'b0, alm_flag_q, evt_q, run_q, busy};
        if (addr_i == A_IEN)  rdata_o = {4'b0, ien_q, 2'b00};
      end
    endcase
  end

  assign irq_timer_o = irq_timer_q;
  assign irq_alarm_o = alm_flag_q && ien_q[1];

  AST_ALARM_AFTER_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_flag_q) |-> $past(upd, 2)); // R9
  AST_ALARM_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[6] && !alarm_hit) |=> !alm_flag_q); // R9
  AST_TIMER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_timer_o |=> !irq_timer_o); // R11
  AST_SEC_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> evt_q[0]); // R8
endmodule

// File: tb/tb_rtc_bcd_core.sv
`timescale 1ns/1ps
module tb_rtc_bcd_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       we_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_timer_o, irq_alarm_o;

  int nchk = 0;
  int nfail = 0;
  int tcnt = 0;
  logic tclr = 1'b0;
  bit done = 1'b0;

  rtc_bcd_core #(.TICKS_PER_SEC(8)) dut (.*);

  always #2 clk_i = ~clk_i;

  always @(negedge clk_i) if (rst_ni) tick_i <= ~tick_i;

  always @(posedge clk_i) begin
    if (tclr) tcnt <= 0;
    else if (irq_timer_o) tcnt <= tcnt + 1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wait_update();
    logic [7:0] s;
    do rd(8'h44, s); while (!s[0]);
    do rd(8'h44, s); while (s[0]);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic set_time(input logic [7:0] yr, mon, day, hr, mn, sc);
    wr(8'h40, 8'h00);
    wr(8'h14, yr); wr(8'h10, mon); wr(8'h0C, day);
    wr(8'h08, hr); wr(8'h04, mn); wr(8'h00, sc);
  endtask

  task automatic expect_time(input string req, input logic [7:0] yr, mon, day, hr, mn, sc);
    logic [7:0] v;
    rd(8'h14, v); check(req, v, yr);
    rd(8'h10, v); check(req, v, mon);
    rd(8'h0C, v); check(req, v, day);
    rd(8'h08, v); check(req, v, hr);
    rd(8'h04, v); check(req, v, mn);
    rd(8'h00, v); check(req, v, sc);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    expect_time("R1", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(8'h40, v); check("R1", v, 8'h00);
    rd(8'h44, v); check("R1", v, 8'h00);
    rd(8'h48, v); check("R1", v, 8'h00);
    rd(8'h2C, v); check("R1", v, 8'h00);
  endtask

  task automatic t_map_stopped();
    logic [7:0] v;
    set_time(8'h25, 8'h07, 8'h14, 8'h12, 8'h34, 8'h56);
    expect_time("R3", 8'h25, 8'h07, 8'h14, 8'h12, 8'h34, 8'h56);
    repeat (40) @(negedge clk_i);
    expect_time("R3", 8'h25, 8'h07, 8'h14, 8'h12, 8'h34, 8'h56);
    rd(8'h44, v); check("R5", v & 8'h01, 8'h00);
    wr(8'h30, 8'h09); rd(8'h30, v); check("R2", v, 8'h09);
    wr(8'h30, 8'h00);
    wr(8'h48, 8'h0C); rd(8'h48, v); check("R2", v, 8'h0C);
    wr(8'h48, 8'h00);
    wr(8'h40, 8'h01); rd(8'h40, v); check("R2", v, 8'h01);
    rd(8'h44, v); check("R2", v & 8'h02, 8'h02);
  endtask

  task automatic t_count();
    set_time(8'h25, 8'h07, 8'h14, 8'h12, 8'h34, 8'h09);
    wr(8'h40, 8'h01);
    wait_update();
    expect_time("R4", 8'h25, 8'h07, 8'h14, 8'h12, 8'h34, 8'h10);
    wait_update();
    expect_time("R4", 8'h25, 8'h07, 8'h14, 8'h12, 8'h34, 8'h11);
  endtask

  task automatic roll(input string req, input logic [7:0] yr, mon, day,
                      input logic [7:0] eyr, emon, eday);
    set_time(yr, mon, day, 8'h23, 8'h59, 8'h59);
    wr(8'h40, 8'h01);
    wait_update();
    expect_time(req, eyr, emon, eday, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_rollovers();
    logic [7:0] v;
    roll("R6", 8'h26, 8'h04, 8'h30, 8'h26, 8'h05, 8'h01);
    roll("R6", 8'h26, 8'h01, 8'h31, 8'h26, 8'h02, 8'h01);
    roll("R7", 8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01);
    roll("R7", 8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29);
    roll("R7", 8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01);
    roll("R7", 8'h16, 8'h02, 8'h28, 8'h16, 8'h02, 8'h29);
    wr(8'h44, 8'h7C);
    roll("R6", 8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01);
    wr(8'h40, 8'h00);
    rd(8'h44, v); check("R8", v, 8'h3C);
    wr(8'h44, 8'h0C);
    rd(8'h44, v); check("R8", v, 8'h30);
    wr(8'h44, 8'h30);
    rd(8'h44, v); check("R8", v, 8'h00);
  endtask

  task automatic set_alarm(input logic [7:0] yr, mon, day, hr, mn, sc);
    wr(8'h34, yr); wr(8'h30, mon); wr(8'h2C, day);
    wr(8'h28, hr); wr(8'h24, mn); wr(8'h20, sc);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    set_time(8'h25, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30);
    set_alarm(8'h25, 8'h06, 8'h15, 8'h10, 8'h20, 8'h31);
    wr(8'h44, 8'h7C);
    wr(8'h48, 8'h08);
    check("R9", {7'b0, irq_alarm_o}, 8'h00);
    wr(8'h40, 8'h01);
    wait_update();
    wr(8'h40, 8'h00);
    rd(8'h44, v); check("R9", v & 8'h40, 8'h40);
    check("R9", {7'b0, irq_alarm_o}, 8'h01);
    wr(8'h48, 8'h00);
    check("R9", {7'b0, irq_alarm_o}, 8'h00);
    wr(8'h48, 8'h08);
    check("R9", {7'b0, irq_alarm_o}, 8'h01);
    wr(8'h44, 8'h40);
    rd(8'h44, v); check("R9", v & 8'h40, 8'h00);
    check("R9", {7'b0, irq_alarm_o}, 8'h00);
    set_time(8'h25, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30);
    wr(8'h34, 8'h26);
    wr(8'h40, 8'h01);
    wait_update();
    wr(8'h40, 8'h00);
    rd(8'h44, v); check("R10", v & 8'h40, 8'h00);
    check("R10", {7'b0, irq_alarm_o}, 8'h00);
    set_time(8'h25, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30);
    wr(8'h34, 8'h25); wr(8'h28, 8'h11);
    wr(8'h40, 8'h01);
    wait_update();
    wr(8'h40, 8'h00);
    rd(8'h44, v); check("R10", v & 8'h40, 8'h00);
    wr(8'h48, 8'h00);
  endtask

  task automatic t_timer_irq();
    wr(8'h48, 8'h04);
    wr(8'h40, 8'h01);
    wait_update();
    @(negedge clk_i); tclr = 1'b1;
    @(negedge clk_i); tclr = 1'b0;
    repeat (3) wait_update();
    repeat (2) @(negedge clk_i);
    check("R11", 8'(tcnt), 8'd3);
    wr(8'h48, 8'h00);
    @(negedge clk_i); tclr = 1'b1;
    @(negedge clk_i); tclr = 1'b0;
    repeat (2) wait_update();
    check("R11", 8'(tcnt), 8'd0);
    wr(8'h40, 8'h00);
  endtask

  task automatic t_run_write();
    logic [7:0] s;
    set_time(8'h25, 8'h03, 8'h03, 8'h08, 8'h00, 8'h05);
    wr(8'h40, 8'h01);
    do rd(8'h44, s); while (!s[0]);
    wr(8'h04, 8'h45);
    do rd(8'h44, s); while (s[0]);
    repeat (4) @(negedge clk_i);
    rd(8'h04, s); check("R12", s, 8'h45);
    rd(8'h00, s); check("R12", s, 8'h06);
    wr(8'h08, 8'h09);
    repeat (4) @(negedge clk_i);
    rd(8'h08, s); check("R12", s, 8'h09);
    wr(8'h40, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_map_stopped();
    t_count();
    t_rollovers();
    t_alarm();
    t_timer_irq();
    t_run_write();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule